// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block is the command front end of a synchronous model of a parallel NOR-style flash. It watches host write cycles, each an address, a data byte and a one-cycle write strobe. It looks for the six-write block-erase sequence. Two unlock writes come first, then an erase setup write, then two more unlock writes, and last a confirm write whose address names a block. The named block is recorded in a bitmap of blocks to be erased.

Once the first confirm is accepted, a collection window opens. Each further confirm write adds its block to the bitmap and restarts the window timer, with no unlock writes needed. When the timer runs out without a new confirm, the sequencer gives the bitmap to an erase engine. It sends a one-cycle start strobe and waits for the engine's done input. The engine first programs every selected block to 00h and then erases it to FFh, so the host never pre-programs anything. From the sixth write until done, reads return status: a status-mode flag, and a timer bit that shows whether the window is still open or erasing has begun. A parameter selects the unlock addresses for byte-wide or word-wide addressing.

Top module: `erase_cmd_seq`

## Requirements
- R1: After reset, eraseMask is zero and statusMode, timerBit, busy and eraseStart are all low.
- R2: An unlock write is data AAh at the first unlock address followed by data 55h at the second unlock address. The setup write is data 80h at the first unlock address. In word mode (WORD_MODE=1) the first and second unlock addresses are 555h and 2AAh. In byte mode they are AAAh and 555h. A sequence that uses the other mode's addresses is not accepted.
- R3: A sixth write with data 30h sets bit wrAddr[BLK_LSB +: BLK_W] of eraseMask. After that write, statusMode is high and timerBit is low.
- R4: A wrong address or wrong data on any of writes one to five, or data other than 30h on the sixth write, returns the block to read-array mode with eraseMask zero and statusMode low.
- R5: While the window is open, each 30h write sets the mask bit of the block at its address. No unlock writes are needed, and bits already set stay set.
- R6: The window timer restarts on every accepted confirm. Erasing starts exactly TIMEOUT clock cycles after the last confirm write is sampled.
- R7: timerBit is low for the whole window and high from the first erasing cycle until done.
- R8: eraseStart is high for exactly one cycle, the first cycle in which busy is high. busy stays high until done.
- R9: eraseDone while busy clears eraseMask and drops busy, statusMode and timerBit at the next clock edge.
- R10: While erasing, writes change neither the mask nor the state. eraseDone outside erasing has no effect.
- R11: A write with data other than 30h while the window is open aborts the command. eraseMask is cleared and the block returns to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one write per cycle high |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data byte |
| eraseDone | input | 1 | Erase engine finished |
| eraseMask | output | NUM_BLOCKS | Blocks collected for erase |
| eraseStart | output | 1 | One-cycle start strobe to the erase engine |
| busy | output | 1 | Erase handed off and not yet done |
| statusMode | output | 1 | Reads return status instead of array data |
| timerBit | output | 1 | Low while the window is open, high while erasing |

## Verification
On every cycle, the assertions check that the start strobe coincides with the rise of busy and lasts one cycle, and that busy always comes with a non-empty mask. They also check that done empties the mask on the next edge, that the window counter never passes its limit, and that writes cannot move the sequencer out of the erasing state. Only the bench scenarios can show the rest. That covers which address and data patterns arm the sequence in each addressing mode, where an abort lands, that the bitmap holds the right blocks, and the exact cycle in which a restarted window expires.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_SETUP    = 8'h80;
  localparam logic [7:0] CMD_CONFIRM  = 8'h30;

  typedef enum logic [2:0] {
    ST_READ,    // expect first unlock
    ST_GOT1,    // expect second unlock
    ST_GOT2,    // expect setup
    ST_GOT3,    // expect first unlock again
    ST_GOT4,    // expect second unlock again
    ST_GOT5,    // expect first confirm
    ST_WINDOW,  // collection window open
    ST_ERASE    // handed to erase engine
  } seqState_t;

  typedef struct packed {
    logic clrMask;
    logic setBit;
    logic clrTimer;
    logic incTimer;
    logic fireStart;
  } seqCtl_t;

endpackage

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter bit WORD_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              timerExpired,
  input  logic              eraseDone,
  output seqCtl_t           ctl,
  output logic              inWindow,
  output logic              inErase
);

  localparam logic [ADDR_W-1:0] UNLOCK_ADDR1 = WORD_MODE ? ADDR_W'(12'h555) : ADDR_W'(12'hAAA);
  localparam logic [ADDR_W-1:0] UNLOCK_ADDR2 = WORD_MODE ? ADDR_W'(12'h2AA) : ADDR_W'(12'h555);

  seqState_t state, nextState;

  logic hitUnlockA, hitUnlockB, hitSetup, hitConfirm;
  assign hitUnlockA = (wrAddr == UNLOCK_ADDR1) && (wrData == CMD_UNLOCK_A);
  assign hitUnlockB = (wrAddr == UNLOCK_ADDR2) && (wrData == CMD_UNLOCK_B);
  assign hitSetup   = (wrAddr == UNLOCK_ADDR1) && (wrData == CMD_SETUP);
  assign hitConfirm = (wrData == CMD_CONFIRM);

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_READ: if (wrEn && hitUnlockA) nextState = ST_GOT1;
      ST_GOT1: if (wrEn) nextState = hitUnlockB ? ST_GOT2 : ST_READ;
      ST_GOT2: if (wrEn) nextState = hitSetup   ? ST_GOT3 : ST_READ;
      ST_GOT3: if (wrEn) nextState = hitUnlockA ? ST_GOT4 : ST_READ;
      ST_GOT4: if (wrEn) nextState = hitUnlockB ? ST_GOT5 : ST_READ;
      ST_GOT5: begin
        if (wrEn) begin
          if (hitConfirm) begin
            nextState    = ST_WINDOW;
            ctl.setBit   = 1'b1;
            ctl.clrTimer = 1'b1;
          end else begin
            nextState = ST_READ;
          end
        end
      end
      ST_WINDOW: begin
        if (wrEn) begin
          ctl.clrTimer = 1'b1;
          if (hitConfirm) begin
            ctl.setBit = 1'b1;
          end else begin
            ctl.clrMask = 1'b1;
            nextState   = ST_READ;
          end
        end else if (timerExpired) begin
          ctl.fireStart = 1'b1;
          nextState     = ST_ERASE;
        end else begin
          ctl.incTimer = 1'b1;
        end
      end
      ST_ERASE: begin
        if (eraseDone) begin
          ctl.clrMask = 1'b1;
          nextState   = ST_READ;
        end
      end
      default: nextState = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_READ;
    else       state <= nextState;
  end

  assign inWindow = (state == ST_WINDOW);
  assign inErase  = (state == ST_ERASE);

  // R10: host writes never pull the sequencer out of erasing
  assert_erase_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inErase && !eraseDone) |=> inErase);

  // R4: a failed unlock step always lands in read-array mode
  assert_abort_to_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GOT1 && wrEn && !hitUnlockB) |=> (state == ST_READ));

endmodule

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_LSB    = 9,
  parameter int TIMEOUT    = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCtl_t               ctl,
  input  logic [ADDR_W-1:0]     wrAddr,
  output logic [NUM_BLOCKS-1:0] mask,
  output logic                  timerExpired,
  output logic                  startPulse
);

  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [BLK_W-1:0] blkIdx;
  logic [CNT_W-1:0] count;

  assign blkIdx = wrAddr[BLK_LSB +: BLK_W];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rstN || ctl.clrMask)
        mask[b] <= 1'b0;
      else if (ctl.setBit && (blkIdx == BLK_W'(b)))
        mask[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrTimer) count <= '0;
    else if (ctl.incTimer)     count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) startPulse <= 1'b0;
    else       startPulse <= ctl.fireStart;
  end

  assign timerExpired = (count == CNT_LAST);

  // R6: the window counter never runs past its last value
  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_LAST);

  // R5: collecting a block never drops one already chosen
  assert_mask_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setBit && !ctl.clrMask) |=> ((mask & $past(mask)) == $past(mask)));

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_LSB    = ADDR_W - ((NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1),
  parameter int TIMEOUT    = 20,
  parameter bit WORD_MODE  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [7:0]            wrData,
  input  logic                  eraseDone,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic                  eraseStart,
  output logic                  busy,
  output logic                  statusMode,
  output logic                  timerBit
);

  seqCtl_t ctl;
  logic    timerExpired, inWindow, inErase;

  erase_seq_ctrl #(.ADDR_W(ADDR_W), .WORD_MODE(WORD_MODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerExpired(timerExpired), .eraseDone(eraseDone),
    .ctl(ctl), .inWindow(inWindow), .inErase(inErase)
  );

  erase_seq_dp #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS), .BLK_LSB(BLK_LSB),
                 .TIMEOUT(TIMEOUT)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr),
    .mask(eraseMask), .timerExpired(timerExpired), .startPulse(eraseStart)
  );

  assign busy       = inErase;
  assign timerBit   = inErase;
  assign statusMode = inWindow | inErase;

  // R8: the start strobe marks the first busy cycle and lasts one cycle
  assert_start_on_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> eraseStart);
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  // R3: erasing is never started with an empty block set
  assert_busy_has_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (eraseMask != '0));

  // R9: done empties the set and releases busy
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && eraseDone) |=> (!busy && eraseMask == '0 && !statusMode));

endmodule

// File: tb/erase_cmd_seq_tb.sv
module erase_cmd_seq_tb_top;

  localparam int ADDR_W = 12;
  localparam int NB     = 8;
  localparam int BLSB   = 9;
  localparam int TMO    = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addrW = '0, addrB = '0;
  logic [7:0] wrData = '0;
  logic eraseDone = 1'b0;

  logic [NB-1:0] maskW, maskB;
  logic startW, startB, busyW, busyB, statW, statB, tbW, tbB;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  erase_cmd_seq #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NB), .BLK_LSB(BLSB),
                  .TIMEOUT(TMO), .WORD_MODE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(addrW), .wrData(wrData),
    .eraseDone(eraseDone), .eraseMask(maskW), .eraseStart(startW),
    .busy(busyW), .statusMode(statW), .timerBit(tbW));

  erase_cmd_seq #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NB), .BLK_LSB(BLSB),
                  .TIMEOUT(TMO), .WORD_MODE(1'b0)) dutByte_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(addrB), .wrData(wrData),
    .eraseDone(eraseDone), .eraseMask(maskB), .eraseStart(startB),
    .busy(busyB), .statusMode(statB), .timerBit(tbB));

  function automatic logic [ADDR_W-1:0] unlockAddr(input bit word, input int which);
    if (word) return (which == 1) ? 12'h555 : 12'h2AA;
    else      return (which == 1) ? 12'hAAA : 12'h555;
  endfunction

  function automatic logic [ADDR_W-1:0] blockAddr(input int blk, input logic [8:0] low);
    return {3'(blk), low};
  endfunction

  function automatic logic [11:0] packExp(input logic [NB-1:0] m, input logic st,
      input logic tb, input logic bz, input logic es);
    return {m, st, tb, bz, es};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expBoth(input string req, input logic [NB-1:0] m, input logic st,
      input logic tb, input logic bz, input logic es);
    chk({req, " word"}, 32'(packExp(maskW, statW, tbW, busyW, startW)), 32'(packExp(m, st, tb, bz, es)));
    chk({req, " byte"}, 32'(packExp(maskB, statB, tbB, busyB, startB)), 32'(packExp(m, st, tb, bz, es)));
  endtask

  task automatic wr(input logic [ADDR_W-1:0] aW, input logic [ADDR_W-1:0] aB, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addrW = aW; addrB = aB; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrU(input int which, input logic [7:0] d);
    wr(unlockAddr(1'b1, which), unlockAddr(1'b0, which), d);
  endtask

  task automatic pulseDone();
    @(negedge clk); eraseDone = 1'b1;
    @(negedge clk); eraseDone = 1'b0;
  endtask

  // Writes step s (1..5) of the preamble, correct or corrupted.
  task automatic stepWrite(input int s, input bit bad);
    logic [7:0] d;
    int which;
    case (s)
      1: begin which = 1; d = 8'hAA; end
      2: begin which = 2; d = 8'h55; end
      3: begin which = 1; d = 8'h80; end
      4: begin which = 1; d = 8'hAA; end
      default: begin which = 2; d = 8'h55; end
    endcase
    if (bad) begin
      if ($urandom_range(0, 1) == 0) d = 8'h12;
      else which = (which == 1) ? 2 : 1;
    end
    wrU(which, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [NB-1:0] expMask;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expBoth("R1 reset state", '0, 0, 0, 0, 0);

    // R10: done outside erasing does nothing
    pulseDone();
    expBoth("R10 idle done ignored", '0, 0, 0, 0, 0);

    // R2: word-mode addresses arm only the word instance
    for (int s = 1; s <= 5; s++) begin
      case (s)
        1: wr(12'h555, 12'h555, 8'hAA);
        2: wr(12'h2AA, 12'h2AA, 8'h55);
        3: wr(12'h555, 12'h555, 8'h80);
        4: wr(12'h555, 12'h555, 8'hAA);
        default: wr(12'h2AA, 12'h2AA, 8'h55);
      endcase
    end
    wr(blockAddr(5, 9'h003), blockAddr(5, 9'h003), 8'h30);
    chk("R2 word mode arms", 32'({maskW, statW}), 32'({8'h20, 1'b1}));
    chk("R2 byte mode rejects word addresses", 32'({maskB, statB}), 32'({8'h00, 1'b0}));
    repeat (TMO) @(negedge clk);
    chk("R7 word erasing", 32'({busyW, tbW}), 32'h3);
    pulseDone();
    chk("R9 word done", 32'({maskW, busyW, statW}), 32'h0);

    // Constrained random sequences with occasional corruption
    for (int it = 0; it < 40; it++) begin
      int errAt, nExtra, blk;
      bit aborted;
      errAt = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      nExtra = $urandom_range(0, 3);
      if (errAt == 7 && nExtra == 0) nExtra = 1;
      aborted = 1'b0;
      expMask = '0;
      for (int s = 1; s <= 5 && !aborted; s++) begin
        stepWrite(s, errAt == s);
        if (errAt == s) begin
          expBoth("R4 bad preamble write aborts", '0, 0, 0, 0, 0);
          aborted = 1'b1;
        end
      end
      if (aborted) continue;
      blk = $urandom_range(0, NB - 1);
      if (errAt == 6) begin
        wr(blockAddr(blk, 9'($urandom)), blockAddr(blk, 9'($urandom)), 8'hD0);
        expBoth("R4 sixth write not confirm", '0, 0, 0, 0, 0);
        continue;
      end
      begin
        logic [ADDR_W-1:0] a;
        a = blockAddr(blk, 9'($urandom));
        wr(a, a, 8'h30);
      end
      expMask[blk] = 1'b1;
      expBoth("R3 first confirm latches block", expMask, 1, 0, 0, 0);
      for (int e = 0; e < nExtra && !aborted; e++) begin
        int gap;
        logic [ADDR_W-1:0] a;
        gap = $urandom_range(0, TMO - 3);
        repeat (gap) @(negedge clk);
        blk = $urandom_range(0, NB - 1);
        a = blockAddr(blk, 9'($urandom));
        if (errAt == 7 && e == nExtra - 1) begin
          wr(a, a, 8'hF0);
          expBoth("R11 non-confirm in window aborts", '0, 0, 0, 0, 0);
          aborted = 1'b1;
        end else begin
          wr(a, a, 8'h30);
          expMask[blk] = 1'b1;
          expBoth("R5 extra confirm adds block", expMask, 1, 0, 0, 0);
        end
      end
      if (aborted) continue;
      repeat (TMO - 1) @(negedge clk);
      expBoth("R6 window still open before expiry", expMask, 1, 0, 0, 0);
      @(negedge clk);
      expBoth("R7 R8 erasing begins with strobe", expMask, 1, 1, 1, 1);
      @(negedge clk);
      expBoth("R8 strobe ends busy holds", expMask, 1, 1, 1, 0);
      begin
        logic [ADDR_W-1:0] a;
        a = blockAddr((blk + 1) % NB, 9'h0);
        wr(a, a, 8'h30);
        wrU(1, 8'hAA);
        wr(a, a, 8'hF0);
      end
      expBoth("R10 writes ignored while erasing", expMask, 1, 1, 1, 0);
      pulseDone();
      expBoth("R9 done clears and releases", '0, 0, 0, 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule